// File: doc/BRIEF.md
# Selectable Modulation Rate Generator

This block turns a 2 MHz system clock into a low-frequency modulation reference. A chain of clock-enable dividers first brings the clock down to a 40 kHz tick. That tick then passes through a rate stage that divides by 1, 3 or 10, according to a 2-bit select. A divide-by-2 stage follows and produces the slot strobe. A three-digit slot counter (5 × 4 × 4) splits each modulation period into 80 equal time slots. The three selectable periods are therefore 250 Hz, 83 1/3 Hz and 25 Hz.

Every output stays in the 2 MHz clock domain:
- a square wave at the modulation rate,
- a 7-bit slot index,
- a one-cycle slot strobe. The strobe is asserted in the cycle before each slot boundary, so a downstream decoder can qualify on it and never sees the index while it is changing.

The select must be held stable while the block runs. It is changed under reset. A synchronous reset puts the phase at the start of slot 0, with the square wave high.

Top module: `mod_freq_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `seg_idx` = 0, `mod_sq` = 1 and `slot_stb` = 0. The cycle in which reset is released begins slot 0 of a new period.
- R2: With `rate_sel` = 0 the square-wave period is 8000 clock cycles (250 Hz at 2 MHz).
- R3: With `rate_sel` = 1 the square-wave period is 24000 clock cycles (83 1/3 Hz).
- R4: With `rate_sel` = 2 the square-wave period is 80000 clock cycles (25 Hz).
- R5: `rate_sel` = 3 behaves exactly like `rate_sel` = 0: the period is 8000 cycles.
- R6: `slot_stb` is a single-cycle pulse. It fires exactly 80 times per period, at a fixed spacing of period/80 cycles (100, 300 or 1000).
- R7: `seg_idx` changes only in the cycle after a `slot_stb` pulse. It then advances by exactly one, modulo 80.
- R8: `mod_sq` is 1 while `seg_idx` is 0 to 39 and 0 while it is 40 to 79. It rises in the same cycle that `seg_idx` wraps from 79 to 0.
- R9: `seg_idx` never exceeds 79.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Modulation rate: 0 = 250 Hz, 1 = 83 1/3 Hz, 2 = 25 Hz, 3 = same as 0 |
| mod_sq | output | 1 | Modulation square wave, registered |
| slot_stb | output | 1 | One-cycle strobe before each slot boundary |
| seg_idx | output | 7 | Current slot in the period, 0 to 79 |

## Verification
The bound checker watches the slot relations on every cycle:
- the strobe is single-cycle,
- the index holds between strobes and steps by one after each strobe,
- the wrap from 79 to 0 coincides with the square-wave rising edge,
- the square-wave level agrees with the index half,
- the index stays in range,
- the state that follows reset is correct.

The absolute rates can only be shown by the bench scenarios, because they depend on long cycle windows. These are the period for each select value including the aliased code 3, the strobe count of 80 and the exact strobe spacing. A reset in mid-period that snaps the phase back to slot 0 is also shown only by the bench.

// File: rtl/mfd_pkg.sv
// Package: shared types and helpers for the modulation rate generator.
// Assumes: rate codes are 2 bits wide; code 3 is an alias of the fast rate.
package mfd_pkg;

    typedef enum logic [1:0] {
        RATE_FAST  = 2'd0,
        RATE_MID   = 2'd1,
        RATE_SLOW  = 2'd2,
        RATE_ALIAS = 2'd3
    } rate_sel_e;

    // Returns the rate-stage divisor for a select code.
    function automatic int rate_divisor(rate_sel_e sel, int div_mid, int div_low);
        case (sel)
            RATE_MID:  return div_mid;
            RATE_SLOW: return div_low;
            default:   return 1;
        endcase
    endfunction

    // Counter width able to hold 0..n-1, with at least one bit.
    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mfd_stage.sv
// Module: mfd_stage
// A fixed modulo-N enable divider. Each time en has been seen N times,
// tick is asserted for one cycle, in the same cycle as the N-th en.
// Assumes: en is a one-cycle qualifier in the clk domain; N >= 1.
module mfd_stage #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    import mfd_pkg::*;

    localparam int W = cnt_width(N);

    generate
        if (N == 1) begin : g_pass
            // Divide by one: the enable passes straight through.
            assign tick = en;
        end else begin : g_div
            logic [W-1:0] cnt_q;
            logic         at_top;

            assign at_top = (cnt_q == W'(N - 1));
            assign tick   = en && at_top;

            // Counts qualified enables and wraps at N-1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (en) begin
                    cnt_q <= at_top ? '0 : cnt_q + W'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mfd_rate_sel.sv
// Module: mfd_rate_sel
// Divides the prescaled tick by 1, DIV_MID or DIV_LOW, picked by sel.
// Assumes: sel is stable while running (changed under reset only).
module mfd_rate_sel #(
    parameter int DIV_MID = 3,
    parameter int DIV_LOW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       en,
    output logic       tick
);
    import mfd_pkg::*;

    localparam int MAXD = (DIV_MID > DIV_LOW) ? DIV_MID : DIV_LOW;
    localparam int W    = cnt_width(MAXD);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last;
    logic         at_top;

    // Decodes the terminal count for the selected divisor.
    always_comb begin
        last = W'(rate_divisor(rate_sel_e'(sel), DIV_MID, DIV_LOW) - 1);
    end

    assign at_top = (cnt_q == last);
    assign tick   = en && at_top;

    // Counts prescaled ticks up to the selected terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_top ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/mfd_segment.sv
// Module: mfd_segment
// Mixed-radix slot counter (SEG_A x SEG_B x SEG_C digits) that advances on
// each slot strobe. It also drives a square wave that is high for the first
// half of the slots and low for the second half.
// Assumes: SEG_A*SEG_B*SEG_C is even; stb is a one-cycle qualifier.
module mfd_segment #(
    parameter int SEG_A = 5,
    parameter int SEG_B = 4,
    parameter int SEG_C = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    stb,
    output logic [$clog2(SEG_A*SEG_B*SEG_C)-1:0]    idx,
    output logic                                    sq
);
    import mfd_pkg::*;

    localparam int SEG_N          = 3;
    localparam int SLOTS          = SEG_A * SEG_B * SEG_C;
    localparam int IDX_W          = $clog2(SLOTS);
    localparam int SEG_DIV [SEG_N] = '{SEG_A, SEG_B, SEG_C};

    logic [IDX_W-1:0] dig   [SEG_N];
    logic             carry [SEG_N+1];
    logic             sq_q;

    assign carry[0] = stb;

    genvar g;
    generate
        for (g = 0; g < SEG_N; g++) begin : g_digit
            localparam int CW = cnt_width(SEG_DIV[g]);
            logic [CW-1:0] cnt_q;
            logic          top;

            assign top        = (cnt_q == CW'(SEG_DIV[g] - 1));
            assign carry[g+1] = carry[g] && top;
            assign dig[g]     = IDX_W'(cnt_q);

            // Advances this digit when every lower digit rolls over.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (carry[g]) begin
                    cnt_q <= top ? '0 : cnt_q + CW'(1);
                end
            end
        end
    endgenerate

    // Combines the digits into a binary slot index.
    always_comb begin
        int acc;
        acc = 0;
        for (int i = SEG_N - 1; i >= 0; i--) begin
            acc = acc * SEG_DIV[i] + int'(dig[i]);
        end
        idx = IDX_W'(acc);
    end

    // Sets the square wave at the wrap and clears it at the half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= 1'b1;
        end else if (stb) begin
            if (idx == IDX_W'(SLOTS - 1)) begin
                sq_q <= 1'b1;
            end else if (idx == IDX_W'(SLOTS / 2 - 1)) begin
                sq_q <= 1'b0;
            end
        end
    end

    assign sq = sq_q;
endmodule

// File: rtl/mod_freq_div.sv
// Module: mod_freq_div (top)
// Prescales the system clock to a fixed tick, applies the selectable rate
// divisor and a divide-by-HALF_DIV to form the slot strobe, then counts slots.
// Assumes: rate_sel is held stable outside reset; everything is in clk's domain.
module mod_freq_div #(
    parameter int PRE_A    = 10,
    parameter int PRE_B    = 5,
    parameter int DIV_MID  = 3,
    parameter int DIV_LOW  = 10,
    parameter int HALF_DIV = 2,
    parameter int SEG_A    = 5,
    parameter int SEG_B    = 4,
    parameter int SEG_C    = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [1:0]                           rate_sel,
    output logic                                 mod_sq,
    output logic                                 slot_stb,
    output logic [$clog2(SEG_A*SEG_B*SEG_C)-1:0] seg_idx
);
    localparam int PRE_N            = 2;
    localparam int PRE_DIV [PRE_N]  = '{PRE_A, PRE_B};

    logic pre_en [PRE_N+1];
    logic rate_tick;

    assign pre_en[0] = 1'b1;

    genvar p;
    generate
        for (p = 0; p < PRE_N; p++) begin : g_pre
            mfd_stage #(.N(PRE_DIV[p])) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (pre_en[p]),
                .tick  (pre_en[p+1])
            );
        end
    endgenerate

    mfd_rate_sel #(.DIV_MID(DIV_MID), .DIV_LOW(DIV_LOW)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (rate_sel),
        .en    (pre_en[PRE_N]),
        .tick  (rate_tick)
    );

    mfd_stage #(.N(HALF_DIV)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rate_tick),
        .tick  (slot_stb)
    );

    mfd_segment #(.SEG_A(SEG_A), .SEG_B(SEG_B), .SEG_C(SEG_C)) u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (slot_stb),
        .idx   (seg_idx),
        .sq    (mod_sq)
    );
endmodule

// File: rtl/mfd_checker.sv
// Module: mfd_checker
// Cycle-by-cycle properties of the slot strobe, index and square wave.
// Assumes: it is bound to mod_freq_div with matching SLOTS and IDX_W.
module mfd_checker #(
    parameter int SLOTS = 80,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_stb,
    input logic             mod_sq,
    input logic [IDX_W-1:0] seg_idx
);
    // R1: reset leaves slot 0, square wave high, no strobe
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (seg_idx == '0 && mod_sq && !slot_stb));

    // R6: the strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |=> !slot_stb);

    // R7: the index holds when there is no strobe
    a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> $stable(seg_idx));

    // R7: the index steps by one after a strobe that is not at the wrap
    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && seg_idx != IDX_W'(SLOTS - 1)) |=> seg_idx == $past(seg_idx) + IDX_W'(1));

    // R8: the wrap coincides with the square-wave rising edge
    a_r8_wrap_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && seg_idx == IDX_W'(SLOTS - 1)) |=> (seg_idx == '0 && $rose(mod_sq)));

    // R8: the square-wave level matches the index half
    a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
        mod_sq == (seg_idx < IDX_W'(SLOTS / 2)));

    // R9: the index stays in range
    a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx < IDX_W'(SLOTS));
endmodule

bind mod_freq_div mfd_checker #(
    .SLOTS (SEG_A * SEG_B * SEG_C),
    .IDX_W ($clog2(SEG_A * SEG_B * SEG_C))
) u_mfd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .mod_sq   (mod_sq),
    .seg_idx  (seg_idx)
);

// File: tb/test_mod_freq_div.sv
// Directed bench for mod_freq_div: one task per scenario.
module test_mod_freq_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       mod_sq;
    logic       slot_stb;
    logic [6:0] seg_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    mod_freq_div i_mod_freq_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .mod_sq   (mod_sq),
        .slot_stb (slot_stb),
        .seg_idx  (seg_idx)
    );

    // Records one check and prints a line when it fails.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Holds reset for a few edges and checks the state that follows it (R1).
    task automatic apply_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n    = 1'b0;
        rate_sel = sel;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(seg_idx == 7'd0, "R1", "idx in reset", int'(seg_idx), 0);
        chk(mod_sq == 1'b1, "R1", "sq in reset", int'(mod_sq), 1);
        chk(slot_stb == 1'b0, "R1", "stb in reset", int'(slot_stb), 0);
    endtask

    // Runs one full period from reset release and checks rate, strobes, index and wave.
    task automatic run_rate(input logic [1:0] sel, input int exp_period, input string req);
        int slot_len;
        int c;
        int period;
        int stb_cnt;
        int last_c;
        int spacing_err;
        int step_err;
        int map_err;
        int range_err;
        int wrap_idx;
        logic [6:0] prev_idx;
        logic       prev_stb;
        logic       prev_sq;
        slot_len    = exp_period / 80;
        period      = -1;
        stb_cnt     = 0;
        last_c      = 0;
        spacing_err = 0;
        step_err    = 0;
        map_err     = 0;
        range_err   = 0;
        wrap_idx    = -1;
        apply_reset(sel);
        prev_idx = seg_idx;
        prev_stb = slot_stb;
        prev_sq  = mod_sq;
        rst_n    = 1'b1;
        c        = 0;
        while (c < exp_period + 2000) begin
            @(negedge clk);
            c++;
            if (prev_stb) begin
                if (seg_idx != 7'((int'(prev_idx) + 1) % 80)) step_err++;
            end else begin
                if (seg_idx != prev_idx) step_err++;
            end
            if (seg_idx > 7'd79) range_err++;
            if (mod_sq != (seg_idx < 7'd40)) map_err++;
            if (slot_stb) begin
                if (stb_cnt > 0 && (c - last_c) != slot_len) spacing_err++;
                last_c = c;
                stb_cnt++;
            end
            if (mod_sq && !prev_sq) begin
                period   = c;
                wrap_idx = int'(seg_idx);
                break;
            end
            prev_idx = seg_idx;
            prev_stb = slot_stb;
            prev_sq  = mod_sq;
        end
        chk(period == exp_period, req, "period cycles", period, exp_period);
        chk(stb_cnt == 80, "R6", "strobes per period", stb_cnt, 80);
        chk(spacing_err == 0, "R6", "strobe spacing errors", spacing_err, 0);
        chk(step_err == 0, "R7", "index step errors", step_err, 0);
        chk(map_err == 0 && wrap_idx == 0, "R8", "level errors / wrap idx",
            map_err * 1000 + wrap_idx, 0);
        chk(range_err == 0, "R9", "index range errors", range_err, 0);
    endtask

    // Resets in mid-period and checks that the phase returns to slot 0 (R1).
    task automatic t_mid_reset();
        apply_reset(2'd0);
        rst_n = 1'b1;
        repeat (3000) @(negedge clk);
        chk(seg_idx != 7'd0, "R1", "index advanced before reset", int'(seg_idx), 30);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(seg_idx == 7'd0, "R1", "idx after mid reset", int'(seg_idx), 0);
        chk(mod_sq == 1'b1, "R1", "sq after mid reset", int'(mod_sq), 1);
    endtask

    // Ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Runs the scenarios in sequence.
    initial begin
        run_rate(2'd0, 8000,  "R2");
        run_rate(2'd1, 24000, "R3");
        run_rate(2'd2, 80000, "R4");
        run_rate(2'd3, 8000,  "R5");
        t_mid_reset();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule